// File: doc/BRIEF.md
# VLAN Membership Table with Command Sequencer

This block keeps a small table that maps a 12-bit VLAN identifier to a member port mask and an optional priority. Software does not write the table directly. It first places a member mask in a data register, then writes a command word that holds an opcode, a VLAN identifier, a port number and a priority, with a start bit set. A sequencer then visits the table one entry per clock and applies the operation. When it finishes, the start bit reads back as zero.

The supported operations are: load an entry, purge one VLAN, flush the whole table, and remove one port from every entry. A load that finds no slot raises a full flag. A combinational lookup port returns, for any VLAN identifier, a hit flag, the member mask and the stored priority. Frame handling sits outside this block and uses the lookup port.

Top module: `vlan_cmd_table`

## Requirements
- R1: After reset the command word and the data word both read zero, and every lookup misses.
- R2: Command word layout: opcode in bits 2:0, busy in bit 3, full in bit 4, port in bits 11:8, VLAN ID in bits 27:16, priority in bits 30:28, priority enable in bit 31. All other bits read zero. Writing a command word with bit 3 set starts the operation. Busy then reads 1 for exactly 16 cycles and afterwards reads 0. Writing a command word with bit 3 clear only stores its fields and starts nothing.
- R3: A command write that arrives while busy is 1 has no effect on the stored fields or on the operation in progress.
- R4: Data word layout: member mask in bits 9:0 and valid in bit 11. All other bits read zero. A data write while busy is 1 is ignored.
- R5: Opcode 2 (load) with a VLAN ID that is not in the table writes the data mask, the priority and the priority enable into the lowest-index invalid entry. That entry becomes visible to lookup once busy clears.
- R6: A load whose VLAN ID matches a valid entry overwrites that entry and uses no other slot.
- R7: A load that finds neither a match nor a free entry sets full (bit 4) and leaves the table unchanged. Full is cleared when the next command starts.
- R8: Opcode 3 (purge) invalidates only the entry whose VLAN ID matches.
- R9: Opcode 1 (flush) invalidates every entry. Loads work normally afterwards.
- R10: Opcode 4 (remove port) clears the given port's bit in the mask of every valid entry. A port number of 10 or more changes nothing.
- R11: A lookup with no matching valid entry returns hit 0, mask 0, priority 0 and priority enable 0.
- R12: Opcode 0 (no-op) runs its 16 busy cycles and changes neither the table nor the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command word, 1 data word |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Read source: 0 command word, 1 data word |
| rd_data | output | 32 | Read value (combinational) |
| lk_vid | input | 12 | VLAN ID to look up |
| lk_hit | output | 1 | A valid entry matches lk_vid |
| lk_mask | output | 10 | Member mask of the matching entry, else 0 |
| lk_prio_en | output | 1 | Stored priority enable, else 0 |
| lk_prio | output | 3 | Stored priority, else 0 |

## Verification
The properties assume that the write strobe is never X after reset and that a single write targets one register per cycle. They do not assume that software waits for busy to clear, so the bench deliberately issues both a command write and a data write in the middle of an operation. Away from those cases the stimulus waits the full 16 busy cycles before the next command. It reads lookups only between edges, so the comparison never depends on the table changing in the same cycle.

// File: rtl/vlan_cmd_table.sv
module vlan_cmd_table #(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  input  logic [11:0]      lk_vid,
  output logic             lk_hit,
  output logic [PORTS-1:0] lk_mask,
  output logic             lk_prio_en,
  output logic [2:0]       lk_prio
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [2:0]  op_q;
  logic        busy_q, full_q, pen_q;
  logic [3:0]  port_q;
  logic [11:0] vid_q;
  logic [2:0]  prio_q;
  logic [PORTS-1:0] dmask_q;
  logic        dvalid_q;
  logic [IW-1:0] step_q, hit_idx_q, free_idx_q;
  logic        seen_hit_q, seen_free_q;

  logic             ev_q    [ENTRIES];
  logic [11:0]      evid_q  [ENTRIES];
  logic [PORTS-1:0] emask_q [ENTRIES];
  logic [3:0]       eprio_q [ENTRIES];

  logic cur_hit, cur_free, last, any_hit, any_free;
  logic [IW-1:0] tgt;
  logic unused_bits;

  assign unused_bits = ^{wr_data[7:4], wr_data[15:12]};
  assign cur_hit  = ev_q[step_q] && (evid_q[step_q] == vid_q);
  assign cur_free = !ev_q[step_q];
  assign last     = (step_q == LAST);
  assign any_hit  = seen_hit_q | cur_hit;
  assign any_free = seen_free_q | cur_free;
  assign tgt = seen_hit_q ? hit_idx_q : cur_hit ? step_q :
               seen_free_q ? free_idx_q : step_q;

  assign rd_data = rd_sel ? {20'b0, dvalid_q, 1'b0, 10'(dmask_q)}
                          : {pen_q, prio_q, vid_q, 4'b0, port_q, 3'b0, full_q, busy_q, op_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; busy_q <= 1'b0; full_q <= 1'b0; pen_q <= 1'b0;
      port_q <= '0; vid_q <= '0; prio_q <= '0;
      dmask_q <= '0; dvalid_q <= 1'b0;
      step_q <= '0; hit_idx_q <= '0; free_idx_q <= '0;
      seen_hit_q <= 1'b0; seen_free_q <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        ev_q[i] <= 1'b0; evid_q[i] <= '0; emask_q[i] <= '0; eprio_q[i] <= '0;
      end
    end else begin
      if (wr_en && !busy_q) begin
        if (!wr_sel) begin
          op_q   <= wr_data[2:0];
          port_q <= wr_data[11:8];
          vid_q  <= wr_data[27:16];
          prio_q <= wr_data[30:28];
          pen_q  <= wr_data[31];
          if (wr_data[3]) begin
            busy_q <= 1'b1; full_q <= 1'b0; step_q <= '0;
            seen_hit_q <= 1'b0; seen_free_q <= 1'b0;
          end
        end else begin
          dmask_q  <= wr_data[PORTS-1:0];
          dvalid_q <= wr_data[11];
        end
      end
      if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (last) busy_q <= 1'b0;
        case (op_q)
          3'd1: ev_q[step_q] <= 1'b0;
          3'd3: if (cur_hit) ev_q[step_q] <= 1'b0;
          3'd4: if (ev_q[step_q] && port_q < PORTS) emask_q[step_q][port_q] <= 1'b0;
          3'd2: begin
            if (cur_hit && !seen_hit_q) begin seen_hit_q <= 1'b1; hit_idx_q <= step_q; end
            if (cur_free && !seen_free_q) begin seen_free_q <= 1'b1; free_idx_q <= step_q; end
            if (last) begin
              if (any_hit || any_free) begin
                ev_q[tgt] <= 1'b1; evid_q[tgt] <= vid_q;
                emask_q[tgt] <= dmask_q; eprio_q[tgt] <= {pen_q, prio_q};
              end else full_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [IW-1:0] lk_idx;
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ev_q[i] && evid_q[i] == lk_vid) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
  end

  assign lk_mask    = lk_hit ? emask_q[lk_idx] : '0;
  assign lk_prio_en = lk_hit & eprio_q[lk_idx][3];
  assign lk_prio    = lk_hit ? eprio_q[lk_idx][2:0] : 3'b0;
endmodule

module vlan_cmd_table_chk #(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 10
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_sel,
  input logic [31:0] wr_data,
  input logic busy,
  input logic full,
  input logic [2:0] op,
  input logic [$clog2(ENTRIES)-1:0] step,
  input logic [11:0] vid,
  input logic [3:0] port,
  input logic [PORTS-1:0] dmask,
  input logic lk_hit,
  input logic [PORTS-1:0] lk_mask
);
  localparam int CW = $clog2(ENTRIES) + 2;
  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk)
    if (!rst_n || !busy) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 1'b1;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_en && !wr_sel && wr_data[3] |=> busy && step == '0);
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(ENTRIES));
  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step == ($clog2(ENTRIES))'(ENTRIES - 1) |=> !busy);
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && !wr_sel |=> $stable(vid) && $stable(port) && $stable(op));
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && wr_sel |=> $stable(dmask));
  p_full_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(busy) && !busy && op == 3'd2);
  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_mask == '0);
endmodule

bind vlan_cmd_table vlan_cmd_table_chk #(.ENTRIES(ENTRIES), .PORTS(PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .busy(busy_q), .full(full_q), .op(op_q), .step(step_q), .vid(vid_q),
  .port(port_q), .dmask(dmask_q), .lk_hit(lk_hit), .lk_mask(lk_mask)
);

// File: tb/vlan_cmd_table_tb_top.sv
`timescale 1ns/100ps
module vlan_cmd_table_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [11:0] lk_vid = '0;
  logic lk_hit, lk_prio_en;
  logic [9:0] lk_mask;
  logic [2:0] lk_prio;

  always #2 clk = ~clk;

  vlan_cmd_table dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lk_vid(lk_vid), .lk_hit(lk_hit),
    .lk_mask(lk_mask), .lk_prio_en(lk_prio_en), .lk_prio(lk_prio)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] q_exp[$];
  bit q_kind[$];
  string q_tag[$];
  event smp;

  function automatic logic [31:0] cmdw(input logic [2:0] op, input logic go, input logic fl,
                                       input logic [3:0] port, input logic [11:0] vid,
                                       input logic [2:0] pr, input logic pe);
    return {pe, pr, vid, 4'b0, port, 3'b0, fl, go, op};
  endfunction

  function automatic logic [31:0] lkw(input logic hit, input logic [9:0] m,
                                      input logic pe, input logic [2:0] pr);
    return {17'b0, pe, pr, hit, m};
  endfunction

  initial forever begin
    logic [31:0] act, exp;
    bit k;
    string t;
    @(smp);
    k = q_kind.pop_front(); exp = q_exp.pop_front(); t = q_tag.pop_front();
    act = k ? {17'b0, lk_prio_en, lk_prio, lk_hit, lk_mask} : rd_data;
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", t, act, exp);
    end
  end

  task automatic chk_rd(input logic sel, input logic [31:0] exp, input string tag);
    rd_sel = sel; #0.1;
    q_kind.push_back(1'b0); q_exp.push_back(exp); q_tag.push_back(tag);
    -> smp; #0.1;
  endtask

  task automatic chk_lk(input logic [11:0] vid, input logic [31:0] exp, input string tag);
    lk_vid = vid; #0.1;
    q_kind.push_back(1'b1); q_exp.push_back(exp); q_tag.push_back(tag);
    -> smp; #0.1;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic op_run(input logic [31:0] c);
    wr(1'b0, c);
    repeat (16) @(negedge clk);
  endtask

  task automatic load(input logic [11:0] vid, input logic [9:0] m,
                      input logic pe, input logic [2:0] pr);
    wr(1'b1, {20'b0, 1'b1, 1'b0, m});
    op_run(cmdw(3'd2, 1'b1, 1'b0, 4'd0, vid, pr, pe));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_rd(1'b0, 32'h0, "R1 cmd reset");
    chk_rd(1'b1, 32'h0, "R1 data reset");
    chk_lk(12'h000, 32'h0, "R1 R11 lookup miss after reset");

    wr(1'b1, 32'hFFFF_F4A5);
    chk_rd(1'b1, 32'h0000_00A5, "R4 data field masking");
    wr(1'b1, 32'h0000_0AA5);
    chk_rd(1'b1, 32'h0000_0AA5, "R4 data readback");

    wr(1'b0, cmdw(3'd2, 1'b1, 1'b0, 4'd0, 12'h123, 3'd5, 1'b1));
    chk_rd(1'b0, cmdw(3'd2, 1'b1, 1'b0, 4'd0, 12'h123, 3'd5, 1'b1), "R2 busy after start");
    chk_lk(12'h123, 32'h0, "R5 not visible while busy");
    wr(1'b0, cmdw(3'd1, 1'b1, 1'b0, 4'd7, 12'h777, 3'd0, 1'b0));
    wr(1'b1, 32'h0000_0BFF);
    repeat (13) @(negedge clk);
    chk_rd(1'b0, cmdw(3'd2, 1'b1, 1'b0, 4'd0, 12'h123, 3'd5, 1'b1), "R2 R3 busy at cycle 16, write ignored");
    @(negedge clk);
    chk_rd(1'b0, cmdw(3'd2, 1'b0, 1'b0, 4'd0, 12'h123, 3'd5, 1'b1), "R2 busy cleared");
    chk_lk(12'h123, lkw(1'b1, 10'h2A5, 1'b1, 3'd5), "R5 load result");
    chk_rd(1'b1, 32'h0000_0AA5, "R4 data write while busy ignored");

    for (int i = 1; i < 16; i++) load(12'h100 + 12'(i), 10'(i), 1'b0, 3'd0);
    chk_lk(12'h10F, lkw(1'b1, 10'h00F, 1'b0, 3'd0), "R5 last free entry");
    chk_rd(1'b0, cmdw(3'd2, 1'b0, 1'b0, 4'd0, 12'h10F, 3'd0, 1'b0), "R7 no full on last slot");

    load(12'h105, 10'h3C0, 1'b0, 3'd0);
    chk_rd(1'b0, cmdw(3'd2, 1'b0, 1'b0, 4'd0, 12'h105, 3'd0, 1'b0), "R6 overwrite no full");
    chk_lk(12'h105, lkw(1'b1, 10'h3C0, 1'b0, 3'd0), "R6 overwrite mask");

    load(12'h200, 10'h001, 1'b0, 3'd0);
    chk_rd(1'b0, cmdw(3'd2, 1'b0, 1'b1, 4'd0, 12'h200, 3'd0, 1'b0), "R7 full set");
    chk_lk(12'h200, 32'h0, "R7 no entry written");
    chk_lk(12'h101, lkw(1'b1, 10'h001, 1'b0, 3'd0), "R7 table unchanged");

    op_run(cmdw(3'd3, 1'b1, 1'b0, 4'd0, 12'h105, 3'd0, 1'b0));
    chk_rd(1'b0, cmdw(3'd3, 1'b0, 1'b0, 4'd0, 12'h105, 3'd0, 1'b0), "R7 full cleared by next command");
    chk_lk(12'h105, 32'h0, "R8 purged entry misses");
    chk_lk(12'h106, lkw(1'b1, 10'h006, 1'b0, 3'd0), "R8 neighbour kept");

    load(12'h200, 10'h001, 1'b0, 3'd0);
    chk_lk(12'h200, lkw(1'b1, 10'h001, 1'b0, 3'd0), "R5 reuse freed slot");

    op_run(cmdw(3'd4, 1'b1, 1'b0, 4'd2, 12'h0, 3'd0, 1'b0));
    chk_lk(12'h123, lkw(1'b1, 10'h2A1, 1'b1, 3'd5), "R10 remove port 2 entry a");
    chk_lk(12'h107, lkw(1'b1, 10'h003, 1'b0, 3'd0), "R10 remove port 2 entry b");
    chk_lk(12'h200, lkw(1'b1, 10'h001, 1'b0, 3'd0), "R10 bit already clear");
    op_run(cmdw(3'd4, 1'b1, 1'b0, 4'd12, 12'h0, 3'd0, 1'b0));
    chk_lk(12'h10F, lkw(1'b1, 10'h00B, 1'b0, 3'd0), "R10 out of range port no effect");

    op_run(cmdw(3'd0, 1'b1, 1'b0, 4'd0, 12'h10F, 3'd0, 1'b0));
    chk_lk(12'h10F, lkw(1'b1, 10'h00B, 1'b0, 3'd0), "R12 no-op keeps table");
    chk_rd(1'b1, 32'h0000_0801, "R12 no-op keeps data");

    op_run(cmdw(3'd1, 1'b1, 1'b0, 4'd0, 12'h0, 3'd0, 1'b0));
    chk_lk(12'h123, 32'h0, "R9 flush entry a");
    chk_lk(12'h10F, 32'h0, "R9 flush entry b");
    load(12'h055, 10'h155, 1'b1, 3'd2);
    chk_lk(12'h055, lkw(1'b1, 10'h155, 1'b1, 3'd2), "R9 load after flush");

    wr(1'b0, cmdw(3'd1, 1'b0, 1'b0, 4'd0, 12'h0, 3'd0, 1'b0));
    chk_rd(1'b0, 32'h0000_0001, "R2 write without start bit");
    repeat (2) @(negedge clk);
    chk_lk(12'h055, lkw(1'b1, 10'h155, 1'b1, 3'd2), "R2 no operation started");
    chk_lk(12'hABC, 32'h0, "R11 miss returns zeros");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule